// File: doc/BRIEF.md
# Instruction Prefetch Queue with Wait-State Timing

This block runs ahead of a processor's execution unit and reads instruction bytes from program memory into a small byte queue. Memory reads are pipelined: a read issued in one clock returns its byte a programmable number of clocks later, the fetch wait-state count. The number of bytes already buffered plus the number of reads in flight never exceeds the queue depth. Address generation therefore pauses when the queue is full and starts again as soon as a byte is consumed.

The execution unit works in machine cycles of four clocks. On the last clock of each machine cycle it may take one or two bytes. Both bytes of a two-byte instruction are handed over together, and only when both are already buffered. When fewer bytes are held than the consumer asks for, the stall output is high and the core waits. Because fetching keeps running while the core spends extra machine cycles on an instruction, steady streams of one-cycle or two-cycle instructions run without stalls.

A taken branch is signalled by a flush pulse carrying the new target address. In that clock the queue is emptied and every read still in flight is dropped, so fetching starts again at the target. A second wait-state value is kept for the data side of the bus. It can replace the fetch count for data accesses without changing fetch timing.

Top module: `insn_prefetch_queue`

## Requirements
- R1: After reset the queue is empty, `stall` is 1, and the first read is issued at address 0x0000 with `mem_req` high.
- R2: Each issued read uses the current fetch address, which then steps by one and wraps from 0xFFFF to 0x0000. Bytes reach the consumer in fetch-address order.
- R3: A read issued in clock t is completed by sampling `mem_rdata` at the end of clock t+W, where W is `fetch_ws`. A value of 0 counts as 1 and values above 8 count as 8. Settings 4 and 5 are both supported.
- R4: `data_ws_eff` equals `data_ws` when `data_ws_ovr` is 1 and `fetch_ws` otherwise. Neither `data_ws` nor `data_ws_ovr` changes the fetch timing.
- R5: A two-byte take (`take_two`=1) removes two bytes in one clock. `insn_b0` is the oldest buffered byte and `insn_b1` the next one.
- R6: `stall` is 1 exactly when the buffered byte count is below the requested count (1 when `take_two`=0, 2 when `take_two`=1), whatever the value of `take_req`.
- R7: `mc_end` is high on one clock out of every four. A take is accepted only in a clock where `take_req` and `mc_end` are 1 and `stall` and `flush` are 0, so at most one take is accepted per machine cycle.
- R8: Buffered bytes plus reads in flight never exceed 4. With no takes, exactly 4 reads are issued after a flush and `mem_req` then stays low. One more read follows a one-byte take.
- R9: `flush` empties the queue in one clock and discards every read in flight. The next read is issued at `flush_addr`.
- R10: With W of 4 or 5 and a filled queue, a stream of one-byte takes every machine cycle, or of two-byte takes every second machine cycle, sees no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_ws | input | 4 | Fetch wait-state count W |
| data_ws | input | 4 | Override wait-state count for data accesses |
| data_ws_ovr | input | 1 | Selects `data_ws` for data accesses |
| data_ws_eff | output | 4 | Wait-state count the data side must use |
| flush | input | 1 | Branch taken: restart fetching at `flush_addr` |
| flush_addr | input | 16 | Branch target address |
| mem_req | output | 1 | Read issued this clock |
| mem_addr | output | 16 | Address of the read issued this clock |
| mem_rdata | input | 8 | Returned byte, valid W clocks after its read |
| take_req | input | 1 | Execution unit wants an instruction |
| take_two | input | 1 | 1: two-byte instruction, 0: one byte |
| mc_end | output | 1 | Last clock of a machine cycle |
| stall | output | 1 | Not enough bytes buffered for the request |
| insn_b0 | output | 8 | Oldest buffered byte |
| insn_b1 | output | 8 | Second-oldest buffered byte |

## Verification
The assertions assume that `flush` lasts one clock in any given cycle and that `fetch_ws` changes only in a flush clock, so that no read in flight sees its latency change. They also assume that the memory returns each byte exactly W clocks after the request. The bench changes the wait-state setting only together with a flush pulse, and its memory model is a delay line clocked from the same W, so both hold throughout. Takes never overlap a flush, which keeps the checks on queue occupancy free of two events at once.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
    localparam int unsigned PFQ_AW     = 16;
    localparam int unsigned PFQ_DW     = 8;
    localparam int unsigned PFQ_DEPTH  = 4;
    localparam int unsigned PFQ_WS_W   = 4;
    localparam int unsigned PFQ_WS_MAX = 8;
    localparam int unsigned PFQ_MC_LEN = 4;
endpackage

// File: rtl/pfq_mc_timer.sv
module pfq_mc_timer #(
    parameter int unsigned MC_LEN = pfq_pkg::PFQ_MC_LEN
) (
    input  logic clk,
    input  logic rst_n,
    output logic mc_end
);
    localparam int unsigned PW = (MC_LEN > 2) ? $clog2(MC_LEN) : 1;

    typedef struct packed {
        logic [PW-1:0] phase;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.phase == PW'(MC_LEN - 1)) begin
            st_d.phase = '0;
        end else begin
            st_d.phase = st_q.phase + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mc_end = (st_q.phase == PW'(MC_LEN - 1));
endmodule

// File: rtl/pfq_byte_store.sv
module pfq_byte_store #(
    parameter int unsigned DEPTH = pfq_pkg::PFQ_DEPTH,
    parameter int unsigned DW    = pfq_pkg::PFQ_DW,
    localparam int unsigned PW   = $clog2(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    input  logic          pop_two,
    output logic [DW-1:0] head0,
    output logic [DW-1:0] head1,
    output logic [CW-1:0] occ
);
    // DEPTH is a power of two so the pointers wrap naturally.
    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] slot;
        logic [PW-1:0]            rd;
        logic [PW-1:0]            wr;
        logic [CW-1:0]            cnt;
    } store_state_t;

    store_state_t st_d, st_q;
    logic [CW-1:0] pop_n;

    always_comb begin
        st_d  = st_q;
        pop_n = pop ? (pop_two ? CW'(2) : CW'(1)) : '0;
        if (clear) begin
            st_d.rd  = '0;
            st_d.wr  = '0;
            st_d.cnt = '0;
        end else begin
            if (push) begin
                st_d.slot[st_q.wr] = push_data;
                st_d.wr            = st_q.wr + PW'(1);
            end
            st_d.rd  = st_q.rd + PW'(pop_n);
            st_d.cnt = st_q.cnt + CW'(push) - pop_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head0 = st_q.slot[st_q.rd];
    assign head1 = st_q.slot[st_q.rd + PW'(1)];
    assign occ   = st_q.cnt;
endmodule

// File: rtl/pfq_fetch_engine.sv
module pfq_fetch_engine #(
    parameter int unsigned AW     = pfq_pkg::PFQ_AW,
    parameter int unsigned DW     = pfq_pkg::PFQ_DW,
    parameter int unsigned DEPTH  = pfq_pkg::PFQ_DEPTH,
    parameter int unsigned WS_W   = pfq_pkg::PFQ_WS_W,
    parameter int unsigned WS_MAX = pfq_pkg::PFQ_WS_MAX,
    localparam int unsigned CW    = $clog2(DEPTH + 1),
    localparam int unsigned SW    = (WS_MAX > 2) ? $clog2(WS_MAX) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic [AW-1:0]   flush_addr,
    input  logic [WS_W-1:0] ws_cfg,
    input  logic [CW-1:0]   occ,
    input  logic [DW-1:0]   mem_rdata,
    output logic            mem_req,
    output logic [AW-1:0]   mem_addr,
    output logic            push,
    output logic [DW-1:0]   push_data,
    output logic [CW-1:0]   infl
);
    // pend[k] high: a read issued k+1 clocks ago is still owed by memory.
    typedef struct packed {
        logic [AW-1:0]     addr;
        logic [WS_MAX-1:0] pend;
        logic [CW-1:0]     infl;
    } fetch_state_t;

    fetch_state_t st_d, st_q;
    logic [SW-1:0] ret_idx;
    logic          room;
    logic          issue;
    logic          ret;

    // Wait-state count clamped into 1..WS_MAX, then used as a tap index.
    always_comb begin
        if (ws_cfg == '0) begin
            ret_idx = '0;
        end else if (int'(ws_cfg) >= int'(WS_MAX)) begin
            ret_idx = SW'(WS_MAX - 1);
        end else begin
            ret_idx = SW'(ws_cfg - WS_W'(1));
        end
    end

    assign ret   = st_q.pend[ret_idx];
    assign room  = ({1'b0, occ} + {1'b0, st_q.infl}) < (CW + 1)'(DEPTH);
    assign issue = !flush && room;

    always_comb begin
        st_d      = st_q;
        st_d.pend = {st_q.pend[WS_MAX-2:0], issue};
        st_d.infl = st_q.infl + CW'(issue) - CW'(ret);
        if (issue) begin
            st_d.addr = st_q.addr + AW'(1);
        end
        if (flush) begin
            st_d.pend = '0;
            st_d.infl = '0;
            st_d.addr = flush_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_req   = issue;
    assign mem_addr  = st_q.addr;
    assign push      = ret;
    assign push_data = mem_rdata;
    assign infl      = st_q.infl;
endmodule

// File: rtl/insn_prefetch_queue.sv
module insn_prefetch_queue #(
    parameter int unsigned AW     = pfq_pkg::PFQ_AW,
    parameter int unsigned DW     = pfq_pkg::PFQ_DW,
    parameter int unsigned DEPTH  = pfq_pkg::PFQ_DEPTH,
    parameter int unsigned WS_W   = pfq_pkg::PFQ_WS_W,
    parameter int unsigned WS_MAX = pfq_pkg::PFQ_WS_MAX,
    parameter int unsigned MC_LEN = pfq_pkg::PFQ_MC_LEN
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [WS_W-1:0] fetch_ws,
    input  logic [WS_W-1:0] data_ws,
    input  logic            data_ws_ovr,
    output logic [WS_W-1:0] data_ws_eff,
    input  logic            flush,
    input  logic [AW-1:0]   flush_addr,
    output logic            mem_req,
    output logic [AW-1:0]   mem_addr,
    input  logic [DW-1:0]   mem_rdata,
    input  logic            take_req,
    input  logic            take_two,
    output logic            mc_end,
    output logic            stall,
    output logic [DW-1:0]   insn_b0,
    output logic [DW-1:0]   insn_b1
);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [CW-1:0] occ_count;
    logic [CW-1:0] infl_count;
    logic [CW-1:0] need;
    logic          push;
    logic [DW-1:0] push_data;
    logic          accept;

    pfq_mc_timer #(.MC_LEN(MC_LEN)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .mc_end (mc_end)
    );

    pfq_fetch_engine #(
        .AW(AW), .DW(DW), .DEPTH(DEPTH), .WS_W(WS_W), .WS_MAX(WS_MAX)
    ) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .flush_addr (flush_addr),
        .ws_cfg     (fetch_ws),
        .occ        (occ_count),
        .mem_rdata  (mem_rdata),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .push       (push),
        .push_data  (push_data),
        .infl       (infl_count)
    );

    pfq_byte_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (flush),
        .push      (push),
        .push_data (push_data),
        .pop       (accept),
        .pop_two   (take_two),
        .head0     (insn_b0),
        .head1     (insn_b1),
        .occ       (occ_count)
    );

    assign need        = take_two ? CW'(2) : CW'(1);
    assign stall       = (occ_count < need);
    assign accept      = take_req && mc_end && !stall && !flush;
    // Data accesses may use their own count; fetch timing never looks here.
    assign data_ws_eff = data_ws_ovr ? data_ws : fetch_ws;
endmodule

// File: rtl/pfq_checker.sv
module pfq_checker #(
    parameter int unsigned AW    = 16,
    parameter int unsigned DEPTH = 4,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flush,
    input logic [AW-1:0] flush_addr,
    input logic          mem_req,
    input logic [AW-1:0] mem_addr,
    input logic          mc_end,
    input logic [CW-1:0] occ,
    input logic [CW-1:0] infl
);
    // Becomes 1 one clock after reset release so $past never reaches into reset.
    logic armed_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else begin
            armed_q <= 1'b1;
        end
    end

    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !$past(flush)) |->
        (mem_addr == ($past(mem_req) ? $past(mem_addr) + AW'(1) : $past(mem_addr))));

    assert_flush_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(flush)) |->
        (mem_addr == $past(flush_addr) && occ == '0 && infl == '0));

    assert_take_on_mc_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !$past(flush) && occ < $past(occ)) |-> $past(mc_end));

    assert_take_max_two_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !$past(flush)) |-> (int'(occ) + 2 >= int'($past(occ))));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(occ) + int'(infl)) <= int'(DEPTH));
endmodule

bind insn_prefetch_queue pfq_checker #(.AW(AW), .DEPTH(DEPTH)) u_pfq_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .flush_addr (flush_addr),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mc_end     (mc_end),
    .occ        (occ_count),
    .infl       (infl_count)
);

// File: tb/test_insn_prefetch_queue.sv
module test_insn_prefetch_queue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  fetch_ws = 4'd4;
    logic [3:0]  data_ws = 4'd0;
    logic        data_ws_ovr = 1'b0;
    logic [3:0]  data_ws_eff;
    logic        flush = 1'b0;
    logic [15:0] flush_addr = 16'h0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = 8'hEE;
    logic        take_req = 1'b0;
    logic        take_two = 1'b0;
    logic        mc_end, stall;
    logic [7:0]  insn_b0, insn_b1;

    always #10 clk = ~clk;

    insn_prefetch_queue i_insn_prefetch_queue (.*);

    int n_tests = 0;
    int n_fail = 0;
    int req_cnt = 0;
    int stall_hits = 0;
    bit done = 0;
    logic [15:0] next_addr = 16'h0;
    logic [7:0]  exp_q[$];
    logic [16:0] hist [16];

    function automatic logic [7:0] mem_fn(input logic [15:0] a);
        return a[7:0] ^ {a[10:8], a[15:11]} ^ 8'hA5;
    endfunction

    // R3: wait-state clamp 0 -> 1, above 8 -> 8
    function automatic int eff_ws(input logic [3:0] w);
        if (w == 0) return 1;
        if (w > 8) return 8;
        return int'(w);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Memory: byte for a read issued in clock t appears during clock t+W.
    initial for (int k = 0; k < 16; k++) hist[k] = '0;
    always @(posedge clk) begin
        int w;
        logic [16:0] cur, src;
        w   = eff_ws(fetch_ws);
        cur = {mem_req, mem_addr};
        src = (w == 1) ? cur : hist[w-2];
        mem_rdata <= src[16] ? mem_fn(src[15:0]) : 8'hEE;
        for (int k = 15; k > 0; k--) hist[k] <= hist[k-1];
        hist[0] <= cur;
        if (flush) req_cnt = 0;
        else if (rst_n && mem_req) req_cnt++;
    end

    // Scoreboard monitor: compares each accepted take with the expected bytes.
    always @(negedge clk) begin
        #2;
        if (rst_n && take_req && mc_end && !stall && !flush) begin
            if (exp_q.size() == 0) begin
                check(0, "R7", "unexpected accept", 1, 0);
            end else begin
                logic [7:0] e0;
                e0 = exp_q.pop_front();
                check(insn_b0 == e0, "R2/R5", "insn_b0", insn_b0, e0);
                if (take_two) begin
                    logic [7:0] e1;
                    e1 = (exp_q.size() > 0) ? exp_q.pop_front() : 8'h00;
                    check(insn_b1 == e1, "R5", "insn_b1", insn_b1, e1);
                end
            end
        end
    end

    task automatic do_flush(input logic [15:0] a, input logic [3:0] ws);
        @(negedge clk);
        flush = 1'b1;
        flush_addr = a;
        fetch_ws = ws;
        next_addr = a;
        exp_q.delete();
        @(negedge clk);
        flush = 1'b0;
    endtask

    // Driver: pushes the expected bytes, then requests until accepted.
    task automatic take(input bit two);
        exp_q.push_back(mem_fn(next_addr));
        next_addr = next_addr + 16'd1;
        if (two) begin
            exp_q.push_back(mem_fn(next_addr));
            next_addr = next_addr + 16'd1;
        end
        @(negedge clk);
        take_req = 1'b1;
        take_two = two;
        #1;
        while (!(mc_end && !stall)) begin
            if (mc_end && stall) stall_hits++;
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        take_req = 1'b0;
        take_two = 1'b0;
    endtask

    task automatic stream(input int n, input bit two);
        stall_hits = 0;
        for (int i = 0; i < n; i++) begin
            take(two);
            if (two) repeat (4) @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check(stall == 1'b1, "R1", "stall after reset", stall, 1);
        check(mem_addr == 16'h0, "R1", "first address", mem_addr, 0);
        check(mem_req == 1'b1, "R1", "first read issued", mem_req, 1);
        take(0);
        take(0);

        // R8: occupancy limit, stop and resume
        do_flush(16'h0400, 4'd4);
        repeat (30) @(negedge clk);
        check(req_cnt == 4, "R8", "reads issued with no takes", req_cnt, 4);
        check(mem_req == 1'b0, "R8", "fetch stopped when full", mem_req, 0);
        take(0);
        repeat (10) @(negedge clk);
        check(req_cnt == 5, "R8", "fetch resumed after take", req_cnt, 5);

        // R6: stall exactly when too few bytes (W=5)
        do_flush(16'h0800, 4'd5);
        repeat (6) @(negedge clk);
        take_two = 1'b1; #1;
        check(stall == 1'b1, "R6", "one byte, two wanted", stall, 1);
        take_two = 1'b0; #1;
        check(stall == 1'b0, "R6", "one byte, one wanted", stall, 0);
        @(negedge clk);
        take_two = 1'b1; #1;
        check(stall == 1'b0, "R6", "two bytes, two wanted", stall, 0);
        take_two = 1'b0;
        // R5 two-byte takes, oldest first
        take(1);
        take(1);

        // R2 wrap of the fetch address
        do_flush(16'hFFFE, 4'd4);
        take(1);
        take(1);

        // R9: flush with reads in flight
        do_flush(16'h1000, 4'd4);
        repeat (3) @(negedge clk);
        do_flush(16'h2000, 4'd4);
        repeat (20) @(negedge clk);
        check(req_cnt == 4, "R9", "reads after second flush", req_cnt, 4);
        for (int i = 0; i < 4; i++) take(0);

        // R3: other wait-state settings and clamping
        do_flush(16'h3000, 4'd1);
        for (int i = 0; i < 3; i++) take(0);
        do_flush(16'h3100, 4'd8);
        for (int i = 0; i < 3; i++) take(0);
        do_flush(16'h3200, 4'd0);
        for (int i = 0; i < 3; i++) take(0);
        do_flush(16'h3300, 4'd12);
        for (int i = 0; i < 3; i++) take(1);

        // R4: data wait-state selection and fetch independence
        data_ws = 4'd2;
        data_ws_ovr = 1'b0;
        #1;
        check(data_ws_eff == 4'd12, "R4", "no override", data_ws_eff, 12);
        data_ws_ovr = 1'b1;
        #1;
        check(data_ws_eff == 4'd2, "R4", "override", data_ws_eff, 2);
        data_ws = 4'd9;
        do_flush(16'h5000, 4'd4);
        for (int i = 0; i < 3; i++) take(1);

        // R7: machine cycle strobe period and one take per machine cycle
        begin
            int hi = 0;
            int last = -1;
            bit spaced = 1;
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                if (mc_end) begin
                    if (last >= 0 && i - last != 4) spaced = 0;
                    last = i;
                    hi++;
                end
            end
            check(hi == 3 && spaced, "R7", "mc_end one in four", hi, 3);
        end
        exp_q.push_back(mem_fn(next_addr));
        exp_q.push_back(mem_fn(next_addr + 16'd1));
        next_addr = next_addr + 16'd2;
        @(negedge clk);
        take_req = 1'b1;
        take_two = 1'b0;
        repeat (8) @(negedge clk);
        take_req = 1'b0;
        #3;
        check(exp_q.size() == 0, "R7", "accepts over two machine cycles",
              2 - exp_q.size(), 2);

        // R10: sustained streams without stalls
        data_ws_ovr = 1'b0;
        do_flush(16'h4000, 4'd4);
        repeat (24) @(negedge clk);
        stream(12, 0);
        check(stall_hits == 0, "R10", "W4 one-byte stream stalls", stall_hits, 0);
        stream(8, 1);
        check(stall_hits == 0, "R10", "W4 two-byte stream stalls", stall_hits, 0);
        do_flush(16'h4800, 4'd5);
        repeat (24) @(negedge clk);
        stream(12, 0);
        check(stall_hits == 0, "R10", "W5 one-byte stream stalls", stall_hits, 0);
        stream(8, 1);
        check(stall_hits == 0, "R10", "W5 two-byte stream stalls", stall_hits, 0);

        repeat (4) @(negedge clk);
        summary();
    end
endmodule